// File: doc/BRIEF.md
# Vectored Interrupt Controller with Master Enable

This block gathers interrupt requests from eleven on-chip sources (four external interrupt pins, four timer/counters, an analogue-to-digital converter, a watchdog timer and a basic interval timer). Each request pulse sets a request flag. Each flag has its own enable bit. The enable bits sit in two byte-wide registers, and software reaches them through a simple register bus. A master enable flag gates delivery to the CPU. When the master flag is set and at least one enabled flag is pending, the block raises its interrupt line toward the CPU.

The CPU answers with an acknowledge pulse. On that pulse the block takes the highest-priority enabled pending source. It clears that source's request flag, clears the master flag so that service cannot be interrupted, and latches a 16-bit vector address unique to the source. CPU command strobes for enable, disable and return-from-interrupt set or clear the master flag. A separate wake output is asserted whenever an enabled request is pending, whatever the master flag holds, so that it can release the device from STOP mode.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all enable bits, all request flags, the master flag and the vector output are 0, so `irq_o` and `stop_wake_o` are 0.
- R2: The high enable register at address F6h reads and writes the enables of sources 0..7 (priority order INT0, INT1, INT2, INT3, T0, T1, T2, T3), with source 0 in bit 7 and source 7 in bit 0.
- R3: The low enable register at address F4h holds the enables of sources 8 (ADC), 9 (WDT) and 10 (BIT) in bits 7, 6 and 5. Bits 4..0 always read 0 and ignore writes.
- R4: A pulse on `src_req[i]` sets request flag i on the next clock. The flags read at F7h (sources 0..7, same bit layout as F6h) and at F5h (sources 8..10, same layout as F4h). A bus write to either address loads those flags.
- R5: When a request pulse for a source arrives in the same cycle as a bus write or an acknowledge that would clear its flag, the flag ends up set.
- R6: `cpu_ei` sets the master flag and `cpu_di` clears it. If a clear (disable or acknowledge) and a set (enable or return) arrive in the same cycle, the master flag ends up cleared.
- R7: `irq_o` is 1 exactly when the master flag is 1 and some source has both its flag and its enable set.
- R8: Among enabled pending sources the lowest source index wins: INT0 highest, BIT lowest.
- R9: `cpu_ack` while `irq_o` is 1 clears the winner's flag and the master flag and, on the next clock, sets `vec_o` to FFE0h + 2 × winner index. `cpu_ack` while `irq_o` is 0 changes nothing.
- R10: `cpu_reti` sets the master flag to 1.
- R11: `stop_wake_o` is 1 exactly when some source has both its flag and its enable set, regardless of the master flag.
- R12: Any address other than F4h..F7h reads as 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| src_req | input | 11 | Request pulses, index = priority (0 highest) |
| cpu_ei | input | 1 | Enable command: set master flag |
| cpu_di | input | 1 | Disable command: clear master flag |
| cpu_reti | input | 1 | Return from service: set master flag |
| cpu_ack | input | 1 | Service entry acknowledge |
| irq_o | output | 1 | Interrupt request to CPU |
| vec_o | output | 16 | Vector address latched at acknowledge |
| stop_wake_o | output | 1 | STOP-mode release |

## Verification
A corrupted request flag or enable bit shows up in the same cycle on the register read-back and on `stop_wake_o`. The bench compares both every clock against its own model. A wrong master flag is not readable, but it shows on `irq_o` in the same cycle that the first enabled request is pending. A wrong winner or vector appears on `vec_o` one clock after the acknowledge. It also leaves the wrong flag still set, which the next read of F5h or F7h exposes.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC   = 11;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = $clog2(NSRC);

    localparam logic [ADDR_W-1:0] A_EN_LO = 8'hF4;
    localparam logic [ADDR_W-1:0] A_RQ_LO = 8'hF5;
    localparam logic [ADDR_W-1:0] A_EN_HI = 8'hF6;
    localparam logic [ADDR_W-1:0] A_RQ_HI = 8'hF7;

    typedef logic [NSRC-1:0] src_vec_t;

    // Byte bit 7 carries the lowest source index of that byte's group.
    function automatic src_vec_t byte_to_src(input logic [BYTE_W-1:0] b, input logic hi);
        src_vec_t r;
        r = '0;
        for (int i = 0; i < NSRC; i++) begin
            if ((hi && i < BYTE_W) || (!hi && i >= BYTE_W))
                r[i] = b[BYTE_W-1-(i % BYTE_W)];
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] src_to_byte(input src_vec_t s, input logic hi);
        logic [BYTE_W-1:0] r;
        r = '0;
        for (int j = 0; j < BYTE_W; j++) begin
            if (hi)
                r[BYTE_W-1-j] = s[j];
            else if (j + BYTE_W < NSRC)
                r[BYTE_W-1-j] = s[j+BYTE_W];
        end
        return r;
    endfunction

    localparam src_vec_t HI_MASK = byte_to_src(8'hFF, 1'b1);
    localparam src_vec_t LO_MASK = byte_to_src(8'hFF, 1'b0);
endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [BYTE_W-1:0] wdata,
    input  src_vec_t          src_req,
    input  src_vec_t          clr_mask,
    output src_vec_t          flag_o,
    output src_vec_t          en_o,
    output logic [BYTE_W-1:0] rdata_o
);
    typedef struct packed {
        src_vec_t flag;
        src_vec_t en;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            case (addr)
                A_EN_HI: regs_d.en   = (regs_q.en   & ~HI_MASK) | byte_to_src(wdata, 1'b1);
                A_EN_LO: regs_d.en   = (regs_q.en   & ~LO_MASK) | byte_to_src(wdata, 1'b0);
                A_RQ_HI: regs_d.flag = (regs_q.flag & ~HI_MASK) | byte_to_src(wdata, 1'b1);
                A_RQ_LO: regs_d.flag = (regs_q.flag & ~LO_MASK) | byte_to_src(wdata, 1'b0);
                default: ;
            endcase
        end
        regs_d.flag = (regs_d.flag & ~clr_mask) | src_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            A_EN_HI: rdata_o = src_to_byte(regs_q.en,   1'b1);
            A_EN_LO: rdata_o = src_to_byte(regs_q.en,   1'b0);
            A_RQ_HI: rdata_o = src_to_byte(regs_q.flag, 1'b1);
            A_RQ_LO: rdata_o = src_to_byte(regs_q.flag, 1'b0);
            default: rdata_o = '0;
        endcase
    end

    assign flag_o = regs_q.flag;
    assign en_o   = regs_q.en;

    for (genvar g = 0; g < NSRC; g++) begin : g_req_chk
        p_req_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            src_req[g] |=> flag_o[g]);
    end

    p_en_hi_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_EN_HI) |=> (src_to_byte(en_o, 1'b1) == $past(wdata)));

    p_en_lo_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_EN_LO) |=> (src_to_byte(en_o, 1'b0) == ($past(wdata) & 8'hE0)));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  src_vec_t         flag_i,
    input  src_vec_t         en_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    src_vec_t pend;

    assign pend  = flag_i & en_i;
    assign any_o = |pend;

    always_comb begin
        idx_o = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) idx_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_master.sv
module irq_master
    import irq_pkg::*;
#(
    parameter int               VEC_W    = 16,
    parameter logic [VEC_W-1:0] VEC_BASE = 16'hFFE0,
    parameter int               VEC_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ei,
    input  logic             di,
    input  logic             reti,
    input  logic             take,
    input  logic [IDX_W-1:0] win_idx,
    output logic             master_o,
    output logic [VEC_W-1:0] vec_o
);
    typedef struct packed {
        logic             master;
        logic [VEC_W-1:0] vec;
    } mst_t;

    mst_t mst_d, mst_q;

    always_comb begin
        mst_d = mst_q;
        if (ei || reti) mst_d.master = 1'b1;
        if (di || take) mst_d.master = 1'b0;
        if (take)
            mst_d.vec = VEC_BASE + VEC_W'(VEC_STEP) * VEC_W'(win_idx);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mst_q <= '0;
        else        mst_q <= mst_d;
    end

    assign master_o = mst_q.master;
    assign vec_o    = mst_q.vec;

    p_take_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !master_o);
    p_di_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        di |=> !master_o);
    p_ei_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ei && !di && !take) |=> master_o);
    p_reti_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !di && !take) |=> master_o);
    p_vec_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(vec_o));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
    import irq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_we,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [10:0] src_req,
    input  logic        cpu_ei,
    input  logic        cpu_di,
    input  logic        cpu_reti,
    input  logic        cpu_ack,
    output logic        irq_o,
    output logic [15:0] vec_o,
    output logic        stop_wake_o
);
    src_vec_t         flag, en, clr_mask;
    logic             any_pend, master, take;
    logic [IDX_W-1:0] win_idx;

    irq_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .we       (bus_we),
        .wdata    (bus_wdata),
        .src_req  (src_req),
        .clr_mask (clr_mask),
        .flag_o   (flag),
        .en_o     (en),
        .rdata_o  (bus_rdata)
    );

    irq_arbiter u_arb (
        .flag_i (flag),
        .en_i   (en),
        .any_o  (any_pend),
        .idx_o  (win_idx)
    );

    irq_master #(
        .VEC_W    (16),
        .VEC_BASE (16'hFFE0),
        .VEC_STEP (2)
    ) u_mst (
        .clk      (clk),
        .rst_n    (rst_n),
        .ei       (cpu_ei),
        .di       (cpu_di),
        .reti     (cpu_reti),
        .take     (take),
        .win_idx  (win_idx),
        .master_o (master),
        .vec_o    (vec_o)
    );

    assign irq_o       = master & any_pend;
    assign stop_wake_o = any_pend;
    assign take        = cpu_ack & irq_o;

    always_comb begin
        clr_mask = '0;
        if (take) clr_mask[win_idx] = 1'b1;
    end

    p_ack_clears_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !src_req[win_idx]) |=> !flag[$past(win_idx)]);
endmodule

// File: tb/tb_irq_vector_ctrl.sv
module tb_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr, bus_wdata, bus_rdata;
    logic        bus_we;
    logic [10:0] src_req;
    logic        cpu_ei, cpu_di, cpu_reti, cpu_ack;
    logic        irq_o, stop_wake_o;
    logic [15:0] vec_o;

    always #5 clk = ~clk;

    irq_vector_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_req(src_req),
        .cpu_ei(cpu_ei), .cpu_di(cpu_di), .cpu_reti(cpu_reti), .cpu_ack(cpu_ack),
        .irq_o(irq_o), .vec_o(vec_o), .stop_wake_o(stop_wake_o)
    );

    int total = 0;
    int bad   = 0;
    bit mflag[11];
    bit men[11];
    bit mmaster;
    int mvec;

    task automatic check(input string tag, input int got, input int exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    function automatic int winner();
        for (int i = 0; i < 11; i++) if (mflag[i] && men[i]) return i;
        return -1;
    endfunction

    function automatic int exp_read(input int a);
        int b = 0;
        case (a)
            'hF6: for (int i = 0; i < 8; i++) if (men[i])   b |= 1 << (7 - i);
            'hF7: for (int i = 0; i < 8; i++) if (mflag[i]) b |= 1 << (7 - i);
            'hF4: for (int i = 8; i < 11; i++) if (men[i])   b |= 1 << (15 - i);
            'hF5: for (int i = 8; i < 11; i++) if (mflag[i]) b |= 1 << (15 - i);
            default: b = 0;
        endcase
        return b;
    endfunction

    function automatic string read_tag(input int a);
        case (a)
            'hF6: return "R2 read F6";
            'hF4: return "R3 read F4";
            'hF5, 'hF7: return "R4 read flags";
            default: return "R12 read unmapped";
        endcase
    endfunction

    // One clock: drive at negedge, check before the edge, update model at the edge.
    task automatic cyc(input int a, input bit we, input int wd, input int rq,
                       input bit ei, input bit di, input bit reti, input bit ack);
        int w;
        bit irqm;
        bus_addr = 8'(a); bus_we = we; bus_wdata = 8'(wd); src_req = 11'(rq);
        cpu_ei = ei; cpu_di = di; cpu_reti = reti; cpu_ack = ack;
        #1;
        w = winner();
        irqm = mmaster && (w >= 0);
        check("R7 irq", int'(irq_o), int'(irqm));
        check("R11 wake", int'(stop_wake_o), int'(w >= 0));
        check("R9 vec", int'(vec_o), mvec);
        check(read_tag(a), int'(bus_rdata), exp_read(a));
        @(posedge clk);
        if (we) begin
            case (a)
                'hF6: for (int i = 0; i < 8; i++)  men[i]   = wd[7-i];
                'hF7: for (int i = 0; i < 8; i++)  mflag[i] = wd[7-i];
                'hF4: for (int i = 8; i < 11; i++) men[i]   = wd[15-i];
                'hF5: for (int i = 8; i < 11; i++) mflag[i] = wd[15-i];
                default: ;
            endcase
        end
        if (ack && irqm) begin
            mflag[w] = 1'b0;
            mvec = 'hFFE0 + 2 * w;
        end
        for (int i = 0; i < 11; i++) if (rq[i]) mflag[i] = 1'b1;
        if (ei || reti) mmaster = 1'b1;
        if (di || (ack && irqm)) mmaster = 1'b0;
        @(negedge clk);
    endtask

    task automatic idle(input int a);
        cyc(a, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL R1 watchdog got=hung exp=finished");
        finish_run();
    end

    initial begin
        int addrs[6] = '{'hF4, 'hF5, 'hF6, 'hF7, 'h10, 'h00};
        rst_n = 1'b0; bus_addr = 0; bus_we = 0; bus_wdata = 0; src_req = 0;
        cpu_ei = 0; cpu_di = 0; cpu_reti = 0; cpu_ack = 0;
        mmaster = 0; mvec = 0;
        for (int i = 0; i < 11; i++) begin mflag[i] = 0; men[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        #1;
        check("R1 irq", int'(irq_o), 0);
        check("R1 wake", int'(stop_wake_o), 0);
        check("R1 vec", int'(vec_o), 0);
        @(negedge clk);
        foreach (addrs[k]) idle(addrs[k]);

        // R2, R3: enable registers and unused low bits
        cyc('hF6, 1, 'hA5, 0, 0, 0, 0, 0);
        cyc('hF4, 1, 'hFF, 0, 0, 0, 0, 0);
        idle('hF6); idle('hF4);

        // R4, R11: requests on T3 (7) and BIT (10), master still off
        cyc('hF7, 0, 0, 11'h480, 0, 0, 0, 0);
        idle('hF7); idle('hF5);

        // R6, R9: enable then acknowledge, vector for T3
        cyc('hF7, 0, 0, 0, 1, 0, 0, 0);
        cyc('hF7, 0, 0, 0, 0, 0, 0, 1);
        idle('hF7);

        // R8, R10: sources 2 and 5 pending with 10, return restores master
        cyc('hF7, 0, 0, 11'h024, 0, 0, 0, 0);
        cyc('hF7, 0, 0, 0, 0, 0, 1, 0);
        cyc('hF7, 0, 0, 0, 0, 0, 0, 1);
        cyc('hF7, 0, 0, 0, 1, 0, 0, 0);
        cyc('hF7, 0, 0, 0, 0, 0, 0, 1);
        cyc('hF5, 0, 0, 0, 1, 0, 0, 0);
        cyc('hF5, 0, 0, 0, 0, 0, 0, 1);
        idle('hF5);

        // R9: acknowledge with irq low is ignored
        cyc('hF7, 0, 0, 0, 0, 0, 0, 1);
        idle('hF7);

        // R5: request beats software clear of the same flag
        cyc('hF7, 1, 'h00, 11'h001, 0, 0, 0, 0);
        idle('hF7);
        cyc('hF7, 1, 'h00, 0, 0, 0, 0, 0);

        // R6: enable and disable together leave master cleared
        cyc('hF7, 0, 0, 11'h001, 1, 1, 0, 0);
        idle('hF7);
        // R5: request and acknowledge of the same source together
        cyc('hF7, 0, 0, 0, 1, 0, 0, 0);
        cyc('hF7, 0, 0, 11'h001, 0, 0, 0, 1);
        idle('hF7);

        // R12: unmapped write ignored
        cyc('h10, 1, 'hFF, 0, 0, 0, 0, 0);
        idle('h10); idle('hF6); idle('hF4); idle('hF7); idle('hF5);

        // Mixed traffic against the model
        for (int n = 0; n < 600; n++) begin
            int a;
            a = addrs[$urandom % 6];
            cyc(a, ($urandom % 4) == 0, $urandom % 256,
                int'($urandom & $urandom & $urandom) & 'h7FF,
                ($urandom % 6) == 0, ($urandom % 14) == 0,
                ($urandom % 9) == 0, ($urandom % 3) == 0);
        end
        finish_run();
    end
endmodule